// File: doc/BRIEF.md
# Resume Event Wake Aggregator

This block keeps a 16-bit resume-enable register that host software reads and writes over a small byte-addressed I/O bus. Each implemented bit of the register is paired with one power-management status level. These levels come from status registers outside the block. When a source whose bit is set becomes active, the block can bring the processor out of a low-power state.

All enabled, active sources are OR-ed into one "hit" term. The block issues a single-cycle wake request on a rising edge of that term, but only while the processor-state input names one of the three resumable states. The interrupt source is special. It is not taken from a status level. Instead it follows the processor interrupt line. A separate active-low control can keep an interrupt that is only the periodic timer tick from waking the system.

Top module: `resume_wake_agg`

## Requirements
- R1: After reset the enable register reads 0000h and `wakeReq` is low.
- R2: A write to the register address with `byteEn` = 01 updates bits 7:0 only and leaves bits 15:8 unchanged.
- R3: A write with `byteEn` = 10 updates bits 15:8 only and leaves bits 7:0 unchanged.
- R4: Only bits 0 to 10 and bit 14 are implemented (mask 47FFh). Bits 11, 12, 13 and 15 ignore writes and read as 0.
- R5: A write to any address other than `REG_ADDR` (default 16h) has no effect. A read of another address, or with `rdEn` low, returns 0.
- R6: In cpuState 2 (C2), 3 (C3) or 4 (POS), a rising edge of the hit term produces `wakeReq` high in the cycle after the edge that samples it. The hit term is the OR over bits of enable AND source.
- R7: An active source whose enable bit is 0 does not raise `wakeReq`.
- R8: In cpuState 0, 1 and 5 to 7, no `wakeReq` is produced.
- R9: `wakeReq` lasts one cycle even while the hit term stays high. A further request needs the hit term to fall and rise again.
- R10: Enable bit 8 is qualified by `cpuIntr`, not by `srcStatus[8]`. `srcStatus[8]` has no effect.
- R11: When `pendIsTick` = 1 and `tickWakeEnN` = 1, `cpuIntr` does not count as a hit. With `tickWakeEnN` = 0 it does.
- R12: Source levels on reserved positions 11, 12, 13 and 15 never raise `wakeReq`, even after all-ones is written to the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Byte address of the access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| byteEn | input | 2 | Byte lanes to write: bit 0 selects 7:0, bit 1 selects 15:8 |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data (combinational) |
| srcStatus | input | 16 | Status levels, one per enable bit position |
| cpuIntr | input | 1 | Processor interrupt line |
| pendIsTick | input | 1 | The only pending interrupt is the timer tick |
| tickWakeEnN | input | 1 | Active-low permission for timer-tick resume |
| cpuState | input | 3 | Processor power state: 0 C0, 1 C1, 2 C2, 3 C3, 4 POS |
| wakeReq | output | 1 | One-cycle wake request |

## Verification
The hardest case to reach is a rising edge of the hit term caused by something other than a status level. Two such causes exist: an enable write while a source is already high, and the timer-tick gate being released while `cpuIntr` is held. A wake that follows from such an edge is easy to miss.

Directed steps hold a source high and then release the gate. After that, thousands of random cycles mix sparse status levels, state codes, interrupt qualifiers and byte-lane writes. A bench model tracks the previous hit value, so each of these edges is predicted exactly.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam int NBYTES = DATA_W / 8;
  localparam logic [DATA_W-1:0] IMPL_MASK = 16'h47FF;
  localparam int IRQ_BIT = 8;

  typedef enum logic [2:0] {
    ST_C0 = 3'd0, ST_C1 = 3'd1, ST_C2 = 3'd2, ST_C3 = 3'd3, ST_POS = 3'd4
  } cpuState_e;

  typedef struct packed {
    logic [NBYTES-1:0] laneWr;
    logic              rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h16
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [NBYTES-1:0] byteEn,
  output ctrlStrobes_t      strobes
);
  logic hitAddr;

  always_comb begin
    hitAddr = (busAddr == REG_ADDR);
    strobes.laneWr = (busWrEn && hitAddr) ? byteEn : '0;
    strobes.rdSel  = busRdEn && hitAddr;
  end
endmodule

// File: rtl/wake_dp.sv
module wake_dp
  import wake_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] srcStatus,
  input  logic              cpuIntr,
  input  logic              pendIsTick,
  input  logic              tickWakeEnN,
  input  logic [2:0]        cpuState,
  output logic [DATA_W-1:0] enReg,
  output logic              wakeReq
);
  logic [DATA_W-1:0] effSrc;
  logic              irqTerm;
  logic              anyHit;
  logic              prevHit;
  logic              stateOk;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enReg[b*8 +: 8] <= '0;
      end else if (strobes.laneWr[b]) begin
        enReg[b*8 +: 8] <= wrData[b*8 +: 8] & IMPL_MASK[b*8 +: 8];
      end
    end
  end

  always_comb begin
    irqTerm = cpuIntr & ~(pendIsTick & tickWakeEnN);
    effSrc = srcStatus;
    effSrc[IRQ_BIT] = irqTerm;
    anyHit = |(enReg & effSrc);
    stateOk = (cpuState == ST_C2) || (cpuState == ST_C3) || (cpuState == ST_POS);
    rdData = strobes.rdSel ? enReg : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevHit <= 1'b0;
      wakeReq <= 1'b0;
    end else begin
      prevHit <= anyHit;
      wakeReq <= anyHit & ~prevHit & stateOk;
    end
  end
endmodule

// File: rtl/resume_wake_agg.sv
module resume_wake_agg
  import wake_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [NBYTES-1:0] byteEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] srcStatus,
  input  logic              cpuIntr,
  input  logic              pendIsTick,
  input  logic              tickWakeEnN,
  input  logic [2:0]        cpuState,
  output logic              wakeReq
);
  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] enReg;

  wake_ctrl #(.REG_ADDR(REG_ADDR)) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .byteEn(byteEn), .strobes(strobes)
  );

  wake_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .rdData(rdData), .srcStatus(srcStatus), .cpuIntr(cpuIntr),
    .pendIsTick(pendIsTick), .tickWakeEnN(tickWakeEnN),
    .cpuState(cpuState), .enReg(enReg), .wakeReq(wakeReq)
  );
endmodule

// File: rtl/wake_agg_chk.sv
module wake_agg_chk
  import wake_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [NBYTES-1:0] byteEn,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] enReg,
  input logic [2:0]        cpuState,
  input logic              wakeReq
);
  a_r2_low_lane_only: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_ADDR && byteEn == 2'b01) |=> enReg[15:8] == $past(enReg[15:8]));

  a_r3_high_lane_only: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_ADDR && byteEn == 2'b10) |=> enReg[7:0] == $past(enReg[7:0]));

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~IMPL_MASK) == '0);

  a_r5_foreign_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(busRdEn && busAddr == REG_ADDR) |-> rdData == '0);

  a_r8_state_gate: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> ($past(cpuState) inside {3'd2, 3'd3, 3'd4}));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> !wakeReq);
endmodule

bind resume_wake_agg wake_agg_chk #(.REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .byteEn(byteEn), .rdData(rdData), .enReg(enReg),
  .cpuState(cpuState), .wakeReq(wakeReq)
);

// File: tb/sim_resume_wake_agg.sv
module sim_resume_wake_agg;
  localparam logic [7:0] A = 8'h16;
  localparam logic [15:0] MASK = 16'h47FF;

  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [1:0] byteEn = '0;
  logic [15:0] wrData = '0, rdData, srcStatus = '0;
  logic cpuIntr = 1'b0, pendIsTick = 1'b0, tickWakeEnN = 1'b0;
  logic [2:0] cpuState = 3'd0;
  logic wakeReq;
  int nRun = 0, nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  resume_wake_agg u0 (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [7:0] ad, logic [15:0] d, logic [1:0] be);
    busAddr = ad; wrData = d; byteEn = be; busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0; byteEn = '0;
  endtask

  task automatic rd(logic [7:0] ad, output logic [15:0] d);
    busAddr = ad; busRdEn = 1'b1; #1;
    d = rdData; busRdEn = 1'b0;
  endtask

  function automatic logic modelHit(logic [15:0] r, logic [15:0] s, logic ci, logic pt, logic tn);
    logic [15:0] e;
    e = s;
    e[8] = ci & ~(pt & tn);
    return |(r & e);
  endfunction

  function automatic logic okState(logic [2:0] st);
    return st == 3'd2 || st == 3'd3 || st == 3'd4;
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [15:0] mReg;
    logic mPrev, hit, expW;
    void'($urandom(32'd1234));
    tick(); tick();
    rstN = 1'b1;
    tick();
    rd(A, d); chk("R1 reset reg", d, 16'h0000);
    chk("R1 reset wake", {15'd0, wakeReq}, 16'h0);
    wr(A, 16'hFFFF, 2'b11); rd(A, d); chk("R4 reserved zero", d, 16'h47FF);
    wr(A, 16'h0000, 2'b01); rd(A, d); chk("R2 low lane", d, 16'h4700);
    wr(A, 16'h00AA, 2'b01); wr(A, 16'h0000, 2'b10); rd(A, d); chk("R3 high lane", d, 16'h00AA);
    wr(8'h18, 16'hFFFF, 2'b11); rd(A, d); chk("R5 foreign write", d, 16'h00AA);
    rd(8'h18, d); chk("R5 foreign read", d, 16'h0000);
    // power button bit 0 in C2
    wr(A, 16'h0001, 2'b11); cpuState = 3'd2; tick();
    srcStatus = 16'h0001; tick(); chk("R6 wake C2", {15'd0, wakeReq}, 16'h1);
    tick(); chk("R9 single pulse", {15'd0, wakeReq}, 16'h0);
    srcStatus = 0; tick(); srcStatus = 16'h0001; cpuState = 3'd4; tick();
    chk("R9 re-arm POS", {15'd0, wakeReq}, 16'h1);
    srcStatus = 0; cpuState = 3'd0; tick(); srcStatus = 16'h0001; tick();
    chk("R8 no wake C0", {15'd0, wakeReq}, 16'h0);
    srcStatus = 0; cpuState = 3'd5; tick(); srcStatus = 16'h0001; tick();
    chk("R8 no wake state5", {15'd0, wakeReq}, 16'h0);
    srcStatus = 0; cpuState = 3'd3; tick(); srcStatus = 16'h0002; tick();
    chk("R7 disabled source", {15'd0, wakeReq}, 16'h0);
    srcStatus = 0; wr(A, 16'h0100, 2'b11); srcStatus = 16'h0100; tick();
    chk("R10 status bit8 ignored", {15'd0, wakeReq}, 16'h0);
    srcStatus = 0; cpuIntr = 1'b1; tick();
    chk("R10 cpuIntr wakes", {15'd0, wakeReq}, 16'h1);
    cpuIntr = 0; pendIsTick = 1; tickWakeEnN = 1; tick(); cpuIntr = 1; tick();
    chk("R11 tick blocked", {15'd0, wakeReq}, 16'h0);
    tickWakeEnN = 0; tick();
    chk("R11 tick allowed", {15'd0, wakeReq}, 16'h1);
    cpuIntr = 0; pendIsTick = 0; wr(A, 16'hFFFF, 2'b11); tick();
    srcStatus = 16'hB800; tick();
    chk("R12 reserved sources", {15'd0, wakeReq}, 16'h0);
    srcStatus = 0; wr(A, 16'h0000, 2'b11); tick();
    // random phase with model
    mReg = 16'h0000; mPrev = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      srcStatus = 16'($urandom) & 16'($urandom) & 16'($urandom);
      cpuIntr = ($urandom % 4) == 0;
      pendIsTick = $urandom % 2;
      tickWakeEnN = $urandom % 2;
      cpuState = 3'($urandom);
      busWrEn = ($urandom % 8) == 0;
      busAddr = (($urandom % 4) == 0) ? 8'h1A : A;
      byteEn = 2'($urandom);
      wrData = 16'($urandom);
      hit = modelHit(mReg, srcStatus, cpuIntr, pendIsTick, tickWakeEnN);
      expW = hit & ~mPrev & okState(cpuState);
      mPrev = hit;
      if (busWrEn && busAddr == A) begin
        if (byteEn[0]) mReg[7:0] = wrData[7:0] & MASK[7:0];
        if (byteEn[1]) mReg[15:8] = wrData[15:8] & MASK[15:8];
      end
      tick();
      busWrEn = 1'b0;
      chk("R6 random wake", {15'd0, wakeReq}, {15'd0, expW});
      if (i % 50 == 0) begin
        rd(A, d); chk("R2 R3 random readback", d, mReg);
      end
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule